// File: doc/BRIEF.md
# MII Transmit Nibble Capture and Code-Group Mapper

This block sits on the PHY side of a media-independent transmit path, clocked by the PHY-sourced transmit clock. That clock runs at 25 MHz at 100 Mbit/s and at 2.5 MHz at 10 Mbit/s. It takes the 4-bit transmit nibble, the transmit enable and the transmit error strobe from the MAC. It registers them on the clock edge chosen by a mode input and presents one 5-bit code group per clock to a downstream encoder.

Inside a frame, data nibbles map through the 4B5B table. A nibble captured with the error strobe high becomes the halt code group. With enable and error both low, the output is the idle code group. The mode input moves sampling to the falling clock edge, which gives the MAC more setup margin. A value captured on a falling edge is moved onto the next rising edge, so the output stage runs on rising edges in both modes. A requested mode change takes effect only while no frame is being captured, so the sampling edge never changes inside a frame.

Top module: `mii_txcap`

## Requirements
- R1: While `rst` is high at a rising edge, the next `code_grp` is 5'b11111 and `frame_active` is 0.
- R2: With the effective mode rising (the value after reset), `txd`, `tx_en` and `tx_er` are taken at the rising edge of `clk`. Values held only between a falling edge and the following rising edge are the ones used.
- R3: With the effective mode falling, the inputs are taken at the falling edge of `clk`. Values changed after that falling edge and before the next rising edge have no effect.
- R4: A nibble taken at rising edge E (rising mode), or at the falling edge just before E (falling mode), appears on `code_grp` after rising edge E+1.
- R5: A nibble taken with `tx_en`=1 and `tx_er`=0 appears as its 4B5B code. In hex order 0..F the codes are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: A nibble taken with `tx_er`=1 appears as 5'b00100, whatever `txd` and `tx_en` are.
- R7: A nibble taken with `tx_en`=0 and `tx_er`=0 appears as 5'b11111, whatever `txd` is.
- R8: `frame_active` equals the `tx_en` of the nibble whose code group is on `code_grp` in the same cycle.
- R9: The effective mode takes the value of `adv_clk_mode` only at a rising edge where three values are all 0: `tx_en` at that edge, `tx_en` at the preceding falling edge, and the enable of the last captured nibble. At every other edge the mode holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, sourced by the PHY |
| rst | input | 1 | Synchronous reset, active high |
| adv_clk_mode | input | 1 | Requested sampling edge: 0 rising, 1 falling |
| txd | input | 4 | Transmit nibble from the MAC |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error strobe from the MAC |
| code_grp | output | 5 | Code group for the downstream encoder |
| frame_active | output | 1 | Enable of the nibble currently on `code_grp` |

## Verification
The bench builds the block with its default `ADV_ENABLE` = 1, so the falling-edge capture register and the edge-selection mode logic are present. Each test cycle drives one value before the falling edge and a different one after it. The code group that comes out therefore shows which edge did the sampling. This makes the two modes distinguishable at the ports, and it also exposes a mode change that is accepted inside a frame. Mode requests are raised mid-frame, on the same cycle a frame starts, and between frames, so each condition in the hold rule is exercised.

// File: rtl/mii_txcap_pkg.sv
package mii_txcap_pkg;

    localparam int NIB_W  = 4;
    localparam int CODE_W = 5;

    typedef logic [NIB_W-1:0]  nibble_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CG_IDLE = 5'b11111;
    localparam code_t CG_HALT = 5'b00100;

    typedef struct packed {
        logic    en;
        logic    er;
        nibble_t dat;
    } mii_tx_t;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    function automatic code_t enc4b5b(input nibble_t n);
        code_t c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

    // Error wins over data; no enable and no error gives idle.
    function automatic code_t map_group(input mii_tx_t s);
        code_t c;
        if (s.er)
            c = CG_HALT;
        else if (s.en)
            c = enc4b5b(s.dat);
        else
            c = CG_IDLE;
        return c;
    endfunction

endpackage

// File: rtl/mii_txcap_mode.sv
module mii_txcap_mode
    import mii_txcap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv_req,
    input  logic      live_en,
    input  logic      fall_en,
    input  logic      held_en,
    output edge_sel_e edge_sel
);

    edge_sel_e mode_q;
    logic      quiet;

    // No enable anywhere in the capture path: safe to switch edges.
    assign quiet = ~live_en & ~fall_en & ~held_en;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= EDGE_RISE;
        else if (quiet)
            mode_q <= adv_req ? EDGE_FALL : EDGE_RISE;
    end

    assign edge_sel = mode_q;

endmodule

// File: rtl/mii_txcap_edge.sv
module mii_txcap_edge
    import mii_txcap_pkg::*;
#(
    parameter bit ADV_ENABLE = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  edge_sel_e edge_sel,
    input  mii_tx_t   live,
    output mii_tx_t   held,
    output logic      fall_en
);

    mii_tx_t held_q;
    mii_tx_t fall_q;

    generate
        if (ADV_ENABLE) begin : g_fall
            always_ff @(negedge clk) begin
                if (rst)
                    fall_q <= '0;
                else
                    fall_q <= live;
            end

            always_ff @(posedge clk) begin
                if (rst)
                    held_q <= '0;
                else if (edge_sel == EDGE_FALL)
                    held_q <= fall_q;
                else
                    held_q <= live;
            end
        end else begin : g_rise_only
            assign fall_q = '0;

            always_ff @(posedge clk) begin
                if (rst)
                    held_q <= '0;
                else
                    held_q <= live;
            end
        end
    endgenerate

    assign held    = held_q;
    assign fall_en = fall_q.en;

endmodule

// File: rtl/mii_txcap_enc.sv
module mii_txcap_enc
    import mii_txcap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mii_tx_t held,
    output code_t   code,
    output logic    active
);

    code_t code_q;
    logic  active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= CG_IDLE;
            active_q <= 1'b0;
        end else begin
            code_q   <= map_group(held);
            active_q <= held.en;
        end
    end

    assign code   = code_q;
    assign active = active_q;

endmodule

// File: rtl/mii_txcap.sv
module mii_txcap
    import mii_txcap_pkg::*;
#(
    parameter bit ADV_ENABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_clk_mode,
    input  logic [NIB_W-1:0]  txd,
    input  logic              tx_en,
    input  logic              tx_er,
    output logic [CODE_W-1:0] code_grp,
    output logic              frame_active
);

    mii_tx_t   live_w;
    mii_tx_t   held_w;
    edge_sel_e edge_w;
    logic      fall_en_w;
    logic      adv_eff;
    logic      mode_fall_w;

    assign live_w.en  = tx_en;
    assign live_w.er  = tx_er;
    assign live_w.dat = txd;

    assign adv_eff     = ADV_ENABLE ? adv_clk_mode : 1'b0;
    assign mode_fall_w = (edge_w == EDGE_FALL);

    mii_txcap_mode u_mode (
        .clk      (clk),
        .rst      (rst),
        .adv_req  (adv_eff),
        .live_en  (tx_en),
        .fall_en  (fall_en_w),
        .held_en  (held_w.en),
        .edge_sel (edge_w)
    );

    mii_txcap_edge #(
        .ADV_ENABLE (ADV_ENABLE)
    ) u_edge (
        .clk      (clk),
        .rst      (rst),
        .edge_sel (edge_w),
        .live     (live_w),
        .held     (held_w),
        .fall_en  (fall_en_w)
    );

    mii_txcap_enc u_enc (
        .clk    (clk),
        .rst    (rst),
        .held   (held_w),
        .code   (code_grp),
        .active (frame_active)
    );

endmodule

// File: rtl/mii_txcap_chk.sv
module mii_txcap_chk
    import mii_txcap_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    tx_en,
    input mii_tx_t held,
    input logic    fall_en,
    input logic    mode_fall,
    input code_t   code_grp,
    input logic    frame_active
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (code_grp == CG_IDLE && !frame_active));

    a_r5_data_code: assert property (@(posedge clk) disable iff (rst)
        (held.en && !held.er) |=> (code_grp == enc4b5b($past(held.dat))));

    a_r6_halt_code: assert property (@(posedge clk) disable iff (rst)
        held.er |=> (code_grp == CG_HALT));

    a_r7_idle_code: assert property (@(posedge clk) disable iff (rst)
        (!held.en && !held.er) |=> (code_grp == CG_IDLE));

    a_r8_active_high: assert property (@(posedge clk) disable iff (rst)
        held.en |=> frame_active);

    a_r8_active_low: assert property (@(posedge clk) disable iff (rst)
        !held.en |=> !frame_active);

    a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_en || fall_en || held.en) |=> $stable(mode_fall));

endmodule

bind mii_txcap mii_txcap_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_en        (tx_en),
    .held         (held_w),
    .fall_en      (fall_en_w),
    .mode_fall    (mode_fall_w),
    .code_grp     (code_grp),
    .frame_active (frame_active)
);

// File: tb/mii_txcap_test.sv
`timescale 1ns/1ps
module mii_txcap_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv_clk_mode = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [4:0] code_grp;
    logic       frame_active;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [4:0] code;
        logic       act;
        string      tag;
    } exp_t;
    exp_t sb[$];

    bit m_mode = 1'b0;
    bit m_cap_en = 1'b0;

    mii_txcap uut (
        .clk          (clk),
        .rst          (rst),
        .adv_clk_mode (adv_clk_mode),
        .txd          (txd),
        .tx_en        (tx_en),
        .tx_er        (tx_er),
        .code_grp     (code_grp),
        .frame_active (frame_active)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] ref_code(input logic [3:0] d, input logic en, input logic er);
        logic [4:0] t [16];
        t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
              5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
        if (er) return 5'b00100;
        if (en) return t[d];
        return 5'b11111;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // One test cycle: value A before the falling edge, value B after it.
    task automatic step(input logic [3:0] ad, input logic ae, input logic ar,
                        input logic [3:0] bd, input logic be, input logic br,
                        input logic adv, input string tag);
        exp_t e;
        logic [3:0] sd;
        logic se, sr;
        bit gate;
        @(posedge clk);
        #1;
        txd = ad; tx_en = ae; tx_er = ar; adv_clk_mode = adv;
        sd = m_mode ? ad : bd;
        se = m_mode ? ae : be;
        sr = m_mode ? ar : br;
        gate = !ae && !be && !m_cap_en;
        m_cap_en = se;
        if (gate) m_mode = adv;
        e.due = cyc + 2;
        e.code = ref_code(sd, se, sr);
        e.act = se;
        e.tag = tag;
        sb.push_back(e);
        #2;
        txd = bd; tx_en = be; tx_er = br;
    endtask

    task automatic send(input logic [3:0] d, input logic en, input logic er,
                        input logic adv, input string tag);
        step(d, en, er, d, en, er, adv, tag);
    endtask

    task automatic do_reset();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b1; tx_en = 1'b0; tx_er = 1'b0; txd = 4'h0; adv_clk_mode = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(code_grp === 5'b11111, "R1 code in reset", code_grp, 5'b11111);
        check(frame_active === 1'b0, "R1 frame_active in reset", {4'b0, frame_active}, 5'b0);
        rst = 1'b0;
        m_mode = 1'b0;
        m_cap_en = 1'b0;
    endtask

    // Scoreboard monitor.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                e = sb.pop_front();
                check(code_grp === e.code, e.tag, code_grp, e.code);
                check(frame_active === e.act, "R8 frame_active", {4'b0, frame_active}, {4'b0, e.act});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R4 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R7: idle with junk on txd.
        for (int i = 0; i < 4; i++) send(4'(i * 5 + 3), 1'b0, 1'b0, 1'b0, "R7 idle");

        // R5: all sixteen nibbles in a frame, rising mode.
        for (int i = 0; i < 16; i++) send(4'(i), 1'b1, 1'b0, 1'b0, "R5 4B5B");
        // R2: rising mode uses the value present at the rising edge.
        for (int i = 0; i < 6; i++)
            step(4'(~i), 1'b1, 1'b0, 4'(i), 1'b1, 1'b0, 1'b0, "R2 rising sample");
        // R6: error inside and outside a frame.
        send(4'h5, 1'b1, 1'b1, 1'b0, "R6 halt in frame");
        send(4'h9, 1'b1, 1'b0, 1'b0, "R5 after halt");
        send(4'h0, 1'b0, 1'b0, 1'b0, "R7 end frame");
        send(4'hA, 1'b0, 1'b1, 1'b0, "R6 halt no enable");
        send(4'h0, 1'b0, 1'b0, 1'b0, "R7 idle");

        // R9: request falling mode between frames; it takes effect.
        send(4'h0, 1'b0, 1'b0, 1'b1, "R9 quiet request");
        send(4'h0, 1'b0, 1'b0, 1'b1, "R9 quiet request");
        // R3: falling mode takes the value before the falling edge.
        for (int i = 0; i < 8; i++)
            step(4'(i + 3), 1'b1, 1'b0, 4'(i + 8), 1'b1, 1'b0, 1'b1, "R3 falling sample");
        // R4: fast alternation with error and idle between nibbles.
        step(4'h7, 1'b1, 1'b1, 4'h2, 1'b0, 1'b0, 1'b1, "R4 falling latency");
        step(4'h0, 1'b0, 1'b0, 4'h6, 1'b1, 1'b0, 1'b1, "R4 falling latency");
        step(4'hC, 1'b1, 1'b0, 4'h1, 1'b0, 1'b1, 1'b1, "R4 falling latency");

        // R9: mid-frame request to return to rising is held off.
        for (int i = 0; i < 5; i++)
            step(4'(i), 1'b1, 1'b0, 4'(15 - i), 1'b1, 1'b0, 1'b0, "R9 held mid-frame");
        step(4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, "R9 frame end");
        send(4'h0, 1'b0, 1'b0, 1'b0, "R9 quiet");
        send(4'h0, 1'b0, 1'b0, 1'b0, "R9 quiet");
        for (int i = 0; i < 4; i++)
            step(4'(i + 1), 1'b1, 1'b0, 4'(i + 10), 1'b1, 1'b0, 1'b0, "R9 rising after switch");
        send(4'h0, 1'b0, 1'b0, 1'b0, "R7 idle");
        send(4'h0, 1'b0, 1'b0, 1'b0, "R7 idle");

        // R9: request on the cycle a frame starts only after the falling edge.
        step(4'h0, 1'b0, 1'b0, 4'h4, 1'b1, 1'b0, 1'b1, "R9 start-edge request");
        for (int i = 0; i < 4; i++)
            step(4'(i + 2), 1'b1, 1'b0, 4'(i + 12), 1'b1, 1'b0, 1'b1, "R9 still rising");
        send(4'h0, 1'b0, 1'b0, 1'b1, "R9 quiet");
        send(4'h0, 1'b0, 1'b0, 1'b1, "R9 quiet");
        for (int i = 0; i < 3; i++)
            step(4'(i + 6), 1'b1, 1'b0, 4'(i), 1'b1, 1'b0, 1'b1, "R3 falling again");
        send(4'h0, 1'b0, 1'b0, 1'b1, "R7 idle");

        // R1: reset in the middle of operation.
        do_reset();
        for (int i = 0; i < 3; i++)
            step(4'(i), 1'b1, 1'b0, 4'(i + 4), 1'b1, 1'b0, 1'b0, "R1 rising after reset");
        send(4'h0, 1'b0, 1'b0, 1'b0, "R7 idle");

        repeat (4) @(posedge clk);
        #1;
        check(sb.size() == 0, "R4 scoreboard drained", 5'(sb.size()), 5'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule